// File: doc/BRIEF.md
# Calendar Clock with Alarm and Stopwatch

This block keeps the time of day, the weekday and a full calendar date in a single synchronous core. Every register runs on the system clock. The core moves forward only when a one-cycle-per-second enable pulse arrives, so no derived or ripple clock exists anywhere in it. The time of day is a 24-hour hh:mm:ss value. The date covers the years 2000 to 2099 and follows the normal month lengths, with the leap day in February.

A set mode lets the user step any single field, including the alarm hour and minute, at any moment. While set mode is active the clock does not count.

The alarm can be armed and disarmed. Once it starts ringing, it stops when the stop input is pressed or after a fixed number of seconds. A one-cycle chime marks every top of the hour.

A stopwatch measures elapsed time in hundredths of a second, separately from the time of day. It has its own start, stop and clear inputs. A view select sends the time, the date or the stopwatch to three two-digit BCD display outputs. The weekday output is always present.

Top module: `cal_alarm_clock`

## Requirements
- R1: After reset the clock reads 00:00:00 on 2000-01-01, the weekday is 6, and the alarm ring, the chime and the stopwatch (00:00.00) are all zero. Weekdays are coded 0 for Sunday through 6 for Saturday.
- R2: Each cycle in which `sec_tick` is high and `set_mode` is low advances the time by one second in the same edge. Seconds run 0–59, minutes 0–59 and hours 0–23. The step from 23:59:59 goes to 00:00:00 and advances the date by one day.
- R3: The weekday steps 0..6 and wraps to 0 on every midnight rollover, and at no other time unless it is set.
- R4: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the two-digit year is a multiple of 4 and 28 otherwise. All other months have 31 days. The day after the last day of the month is day 1 of the next month. The day after December 31 is January 1 of the next year, and year 99 wraps to 00.
- R5: `chime` is high for exactly the one cycle after the edge at which a tick makes minutes and seconds both 00.
- R6: `view_sel` chooses what the outputs `disp_hi`/`disp_mid`/`disp_lo` show, each as a two-digit BCD value (tens in bits 7:4, units in bits 3:0):
  - 0 or 3: hour / minute / second.
  - 1: year / month / day.
  - 2: stopwatch minutes / seconds / hundredths.
- R7: While `set_mode` is high, `sec_tick` is ignored. Each cycle with `set_inc` high adds one to the field named by `set_field`, wrapping back to the start of that field's legal range. The field codes are:
  - 0 seconds (0–59), 1 minutes (0–59), 2 hours (0–23)
  - 3 weekday (0–6), 4 day (1 to the current month length)
  - 5 month (1–12), 6 year (0–99)
  - 7 alarm minute (0–59), 8 alarm hour (0–23)
  - Codes 9–15 change nothing.
- R8: When setting the month or the year makes the current day larger than the new month length, the day is clamped to that length in the same edge.
- R9: `alarm_ring` rises one cycle after the edge at which, with `alarm_arm` high, a tick makes the time equal to the alarm hour and minute with seconds 00. While disarmed the alarm never rings. Dropping `alarm_arm` clears a ring at the next edge.
- R10: A ring clears at the edge after `alarm_stop` is high. Without a stop, it clears one cycle after the RING_SECS-th tick that follows its start.
- R11: A `sw_start` pulse starts the stopwatch and a `sw_stop` pulse stops it; stop wins when both are high. While running, the stopwatch adds one hundredth every CLK_PER_CS cycles and carries 99→0 into seconds and 59→0 into minutes. After SW_MIN_WRAP−1:59.99 it wraps to zero. While stopped it holds its value.
- R12: `sw_clear` zeroes the stopwatch and its divider at the next edge whether running or not, with no count at that edge, and leaves the run state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| set_mode | input | 1 | Set mode: hold time, enable field stepping |
| set_field | input | 4 | Field to step (codes in R7) |
| set_inc | input | 1 | Step the selected field by one |
| alarm_arm | input | 1 | Alarm armed when high |
| alarm_stop | input | 1 | Silence a ringing alarm |
| sw_start | input | 1 | Stopwatch start pulse |
| sw_stop | input | 1 | Stopwatch stop pulse |
| sw_clear | input | 1 | Stopwatch clear pulse |
| view_sel | input | 2 | Display view (codes in R6) |
| disp_hi | output | 8 | Left BCD pair |
| disp_mid | output | 8 | Middle BCD pair |
| disp_lo | output | 8 | Right BCD pair |
| weekday | output | 3 | Day of week, 0 = Sunday |
| alarm_ring | output | 1 | Alarm ringing |
| chime | output | 1 | Top-of-hour pulse |

## Verification
The bench sets three parameters:
- CLK_PER_CS = 3, so the hundredths divider is still exercised but one full stopwatch cycle costs only thousands of clocks.
- SW_MIN_WRAP = 2, so the stopwatch wrap point is reached in a cycle-exact sweep where every clock is compared.
- RING_SECS = 4, so the alarm timeout is reached after a handful of ticks.

With these values the bench can sweep every set-mode field through its full range and wrap. It can roll over the last day of every month for years 00–03 and 99. It also runs two straight hours of ticks with the chime checked at every second.

// File: rtl/cac_pkg.sv
package cac_pkg;

  typedef enum logic [3:0] {
    FLD_SEC   = 4'd0,
    FLD_MIN   = 4'd1,
    FLD_HOUR  = 4'd2,
    FLD_WDAY  = 4'd3,
    FLD_DAY   = 4'd4,
    FLD_MON   = 4'd5,
    FLD_YEAR  = 4'd6,
    FLD_AMIN  = 4'd7,
    FLD_AHOUR = 4'd8
  } field_e;

  typedef enum logic [1:0] {
    VW_TIME  = 2'd0,
    VW_DATE  = 2'd1,
    VW_SW    = 2'd2,
    VW_TIME2 = 2'd3
  } view_e;

  // Days in a month for a two-digit year within 2000..2099.
  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    logic [4:0] n;
    case (mon)
      4'd2:                    n = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
      default:                 n = 5'd31;
    endcase
    return n;
  endfunction

  // Binary 0..99 to a packed pair of BCD digits.
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction

  // Add one, falling back to lo once hi has been reached.
  function automatic logic [6:0] step_wrap(input logic [6:0] v, input logic [6:0] lo,
                                           input logic [6:0] hi);
    return (v >= hi) ? lo : v + 7'd1;
  endfunction

endpackage

// File: rtl/cac_timekeeper.sv
module cac_timekeeper
  import cac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       set_mode,
  input  logic [3:0] set_field,
  input  logic       set_inc,
  output logic [4:0] hour,
  output logic [5:0] min,
  output logic [5:0] sec,
  output logic [2:0] wday,
  output logic [4:0] day,
  output logic [3:0] mon,
  output logic [6:0] year,
  output logic       step
);

  logic [4:0] hour_q;
  logic [5:0] min_q, sec_q;
  logic [2:0] wday_q;
  logic [4:0] day_q;
  logic [3:0] mon_q;
  logic [6:0] year_q;
  logic       step_q;

  // Named internal events.
  logic       tick_go, sec_end, min_end, hour_end, day_end, roll_day;
  logic [4:0] day_lim;
  logic [3:0] mon_set;
  logic [6:0] yr_set;
  logic [4:0] lim_mset, lim_yset;

  always_comb begin
    tick_go  = sec_tick && !set_mode;
    sec_end  = (sec_q == 6'd59);
    min_end  = (min_q == 6'd59);
    hour_end = (hour_q == 5'd23);
    day_lim  = month_len(mon_q, year_q);
    day_end  = (day_q == day_lim);
    roll_day = tick_go && sec_end && min_end && hour_end;
    mon_set  = 4'(step_wrap({3'b000, mon_q}, 7'd1, 7'd12));
    yr_set   = step_wrap(year_q, 7'd0, 7'd99);
    lim_mset = month_len(mon_set, year_q);
    lim_yset = month_len(mon_q, yr_set);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour_q <= '0;
      min_q  <= '0;
      sec_q  <= '0;
      wday_q <= 3'd6;
      day_q  <= 5'd1;
      mon_q  <= 4'd1;
      year_q <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= tick_go;
      if (tick_go) begin
        sec_q <= sec_end ? 6'd0 : sec_q + 6'd1;
        if (sec_end) min_q <= min_end ? 6'd0 : min_q + 6'd1;
        if (sec_end && min_end) hour_q <= hour_end ? 5'd0 : hour_q + 5'd1;
        if (roll_day) begin
          wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;
          day_q  <= day_end ? 5'd1 : day_q + 5'd1;
          if (day_end) begin
            mon_q <= (mon_q == 4'd12) ? 4'd1 : mon_q + 4'd1;
            if (mon_q == 4'd12) year_q <= yr_set;
          end
        end
      end else if (set_mode && set_inc) begin
        case (field_e'(set_field))
          FLD_SEC:  sec_q  <= 6'(step_wrap({1'b0, sec_q}, 7'd0, 7'd59));
          FLD_MIN:  min_q  <= 6'(step_wrap({1'b0, min_q}, 7'd0, 7'd59));
          FLD_HOUR: hour_q <= 5'(step_wrap({2'b00, hour_q}, 7'd0, 7'd23));
          FLD_WDAY: wday_q <= 3'(step_wrap({4'b0000, wday_q}, 7'd0, 7'd6));
          FLD_DAY:  day_q  <= 5'(step_wrap({2'b00, day_q}, 7'd1, {2'b00, day_lim}));
          FLD_MON: begin
            mon_q <= mon_set;
            if (day_q > lim_mset) day_q <= lim_mset;
          end
          FLD_YEAR: begin
            year_q <= yr_set;
            if (day_q > lim_yset) day_q <= lim_yset;
          end
          default: ;
        endcase
      end
    end
  end

  assign hour = hour_q;
  assign min  = min_q;
  assign sec  = sec_q;
  assign wday = wday_q;
  assign day  = day_q;
  assign mon  = mon_q;
  assign year = year_q;
  assign step = step_q;

  // R7: seconds stay put through set mode unless a step is requested
  p_set_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !set_inc) |=> $stable(sec_q));

  // R3: midnight rollover lands on hour 0 and moves the weekday on
  p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    roll_day |=> (hour_q == 5'd0 && wday_q != $past(wday_q)));

  // R4/R8: day always legal for the month shown
  p_day_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_q >= 5'd1 && day_q <= month_len(mon_q, year_q)));

endmodule

// File: rtl/cac_alarm.sv
module cac_alarm
  import cac_pkg::*;
#(
  parameter int RING_SECS = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [4:0] hour,
  input  logic [5:0] min,
  input  logic [5:0] sec,
  input  logic       arm,
  input  logic       stop,
  input  logic       set_mode,
  input  logic [3:0] set_field,
  input  logic       set_inc,
  output logic       ring,
  output logic       chime
);

  localparam int RW = (RING_SECS > 1) ? $clog2(RING_SECS) : 1;

  logic [4:0]    al_hour_q;
  logic [5:0]    al_min_q;
  logic          ring_q;
  logic [RW-1:0] ring_cnt_q;

  logic match_ev, timeout_ev, top_ev;

  always_comb begin
    match_ev   = step && arm && (hour == al_hour_q) && (min == al_min_q) && (sec == 6'd0);
    timeout_ev = ring_q && step && (ring_cnt_q == RW'(RING_SECS - 1));
    top_ev     = step && (min == 6'd0) && (sec == 6'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_hour_q <= '0;
      al_min_q  <= '0;
    end else if (set_mode && set_inc) begin
      case (field_e'(set_field))
        FLD_AMIN:  al_min_q  <= 6'(step_wrap({1'b0, al_min_q}, 7'd0, 7'd59));
        FLD_AHOUR: al_hour_q <= 5'(step_wrap({2'b00, al_hour_q}, 7'd0, 7'd23));
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_q     <= 1'b0;
      ring_cnt_q <= '0;
    end else if (!arm || stop) begin
      ring_q     <= 1'b0;
      ring_cnt_q <= '0;
    end else if (match_ev) begin
      ring_q     <= 1'b1;
      ring_cnt_q <= '0;
    end else if (timeout_ev) begin
      ring_q     <= 1'b0;
      ring_cnt_q <= '0;
    end else if (ring_q && step) begin
      ring_cnt_q <= ring_cnt_q + RW'(1);
    end
  end

  assign ring  = ring_q;
  assign chime = top_ev;

  // R9: a ring only starts from an armed alarm match
  p_ring_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_q) |-> $past(match_ev));

  // R10: stop silences at the next edge
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !ring_q);

  // R5: chime never lasts two cycles
  p_chime_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chime |=> !chime);

endmodule

// File: rtl/cac_stopwatch.sv
module cac_stopwatch #(
  parameter int CLK_PER_CS  = 500000,
  parameter int SW_MIN_WRAP = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start,
  input  logic       sw_stop,
  input  logic       sw_clear,
  output logic [5:0] sw_min,
  output logic [5:0] sw_sec,
  output logic [6:0] sw_cs
);

  localparam int DW = (CLK_PER_CS > 1) ? $clog2(CLK_PER_CS) : 1;

  logic       run_q;
  logic [6:0] cs_q;
  logic [5:0] sec_q, min_q;
  logic       cs_go;

  generate
    if (CLK_PER_CS == 1) begin : g_nodiv
      assign cs_go = run_q;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || sw_clear) div_q <= '0;
        else if (run_q)         div_q <= (div_q == DW'(CLK_PER_CS - 1)) ? '0 : div_q + DW'(1);
      end
      assign cs_go = run_q && (div_q == DW'(CLK_PER_CS - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (sw_stop)  run_q <= 1'b0;
    else if (sw_start) run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sw_clear) begin
      cs_q  <= '0;
      sec_q <= '0;
      min_q <= '0;
    end else if (cs_go) begin
      if (cs_q == 7'd99) begin
        cs_q <= '0;
        if (sec_q == 6'd59) begin
          sec_q <= '0;
          min_q <= (min_q == 6'(SW_MIN_WRAP - 1)) ? 6'd0 : min_q + 6'd1;
        end else begin
          sec_q <= sec_q + 6'd1;
        end
      end else begin
        cs_q <= cs_q + 7'd1;
      end
    end
  end

  assign sw_min = min_q;
  assign sw_sec = sec_q;
  assign sw_cs  = cs_q;

  // R12: clear leaves all digits at zero
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (cs_q == 7'd0 && sec_q == 6'd0 && min_q == 6'd0));

  // R11: a stopped stopwatch holds its count
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !sw_clear) |=> $stable(cs_q));

endmodule

// File: rtl/cal_alarm_clock.sv
module cal_alarm_clock
  import cac_pkg::*;
#(
  parameter int CLK_PER_CS  = 500000,
  parameter int SW_MIN_WRAP = 60,
  parameter int RING_SECS   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       set_mode,
  input  logic [3:0] set_field,
  input  logic       set_inc,
  input  logic       alarm_arm,
  input  logic       alarm_stop,
  input  logic       sw_start,
  input  logic       sw_stop,
  input  logic       sw_clear,
  input  logic [1:0] view_sel,
  output logic [7:0] disp_hi,
  output logic [7:0] disp_mid,
  output logic [7:0] disp_lo,
  output logic [2:0] weekday,
  output logic       alarm_ring,
  output logic       chime
);

  logic [4:0] t_hour, t_day;
  logic [5:0] t_min, t_sec;
  logic [2:0] t_wday;
  logic [3:0] t_mon;
  logic [6:0] t_year;
  logic       t_step;
  logic [5:0] s_min, s_sec;
  logic [6:0] s_cs;

  cac_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_mode(set_mode),
    .set_field(set_field), .set_inc(set_inc),
    .hour(t_hour), .min(t_min), .sec(t_sec), .wday(t_wday),
    .day(t_day), .mon(t_mon), .year(t_year), .step(t_step)
  );

  cac_alarm #(.RING_SECS(RING_SECS)) u_alarm (
    .clk(clk), .rst_n(rst_n), .step(t_step), .hour(t_hour), .min(t_min), .sec(t_sec),
    .arm(alarm_arm), .stop(alarm_stop), .set_mode(set_mode), .set_field(set_field),
    .set_inc(set_inc), .ring(alarm_ring), .chime(chime)
  );

  cac_stopwatch #(.CLK_PER_CS(CLK_PER_CS), .SW_MIN_WRAP(SW_MIN_WRAP)) u_sw (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_stop(sw_stop), .sw_clear(sw_clear),
    .sw_min(s_min), .sw_sec(s_sec), .sw_cs(s_cs)
  );

  always_comb begin
    case (view_e'(view_sel))
      VW_DATE: begin
        disp_hi  = to_bcd(t_year);
        disp_mid = to_bcd({3'b000, t_mon});
        disp_lo  = to_bcd({2'b00, t_day});
      end
      VW_SW: begin
        disp_hi  = to_bcd({1'b0, s_min});
        disp_mid = to_bcd({1'b0, s_sec});
        disp_lo  = to_bcd(s_cs);
      end
      default: begin
        disp_hi  = to_bcd({2'b00, t_hour});
        disp_mid = to_bcd({1'b0, t_min});
        disp_lo  = to_bcd({1'b0, t_sec});
      end
    endcase
  end

  assign weekday = t_wday;

endmodule

// File: tb/sim_cal_alarm_clock.sv
module sim_cal_alarm_clock;

  localparam int P_CS   = 3;
  localparam int P_WRAP = 2;
  localparam int P_RING = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, set_mode = 0, set_inc = 0;
  logic [3:0] set_field = '0;
  logic alarm_arm = 0, alarm_stop = 0;
  logic sw_start = 0, sw_stop = 0, sw_clear = 0;
  logic [1:0] view_sel = '0;
  logic [7:0] disp_hi, disp_mid, disp_lo;
  logic [2:0] weekday;
  logic alarm_ring, chime;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cal_alarm_clock #(.CLK_PER_CS(P_CS), .SW_MIN_WRAP(P_WRAP), .RING_SECS(P_RING)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_mode(set_mode),
    .set_field(set_field), .set_inc(set_inc), .alarm_arm(alarm_arm),
    .alarm_stop(alarm_stop), .sw_start(sw_start), .sw_stop(sw_stop),
    .sw_clear(sw_clear), .view_sel(view_sel), .disp_hi(disp_hi), .disp_mid(disp_mid),
    .disp_lo(disp_lo), .weekday(weekday), .alarm_ring(alarm_ring), .chime(chime)
  );

  function automatic int bcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int b_dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    return 30 + ((mo + (mo > 7 ? 1 : 0)) % 2);
  endfunction

  function automatic int slot(input int s);
    if (s == 0) return int'(disp_hi);
    if (s == 1) return int'(disp_mid);
    return int'(disp_lo);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk3(input string tag, input int v, input int a, input int b, input int c);
    view_sel = 2'(v);
    #1;
    chk(tag, int'(disp_hi), bcd(a));
    chk(tag, int'(disp_mid), bcd(b));
    chk(tag, int'(disp_lo), bcd(c));
  endtask

  task automatic inc(input int f);
    set_mode = 1'b1;
    set_field = 4'(f);
    set_inc = 1'b1;
    @(negedge clk);
    set_inc = 1'b0;
  endtask

  task automatic set_to(input int f, input int v, input int s, input int target);
    view_sel = 2'(v);
    for (int i = 0; i < 130; i++) begin
      #1;
      if (slot(s) == bcd(target)) break;
      inc(f);
    end
  endtask

  task automatic tick_once();
    set_mode = 1'b0;
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  // Stopwatch cycle model
  int m_run = 0, m_div = 0, m_tot = 0;
  task automatic sw_cyc(input string tag, input bit s, input bit p, input bit c);
    sw_start = s; sw_stop = p; sw_clear = c;
    @(posedge clk);
    if (c) begin m_div = 0; m_tot = 0; end
    else if (m_run != 0) begin
      if (m_div == P_CS - 1) begin m_div = 0; m_tot = (m_tot + 1) % (P_WRAP * 6000); end
      else m_div++;
    end
    if (p) m_run = 0; else if (s) m_run = 1;
    @(negedge clk);
    sw_start = 0; sw_stop = 0; sw_clear = 0;
    view_sel = 2'd2;
    #1;
    chk(tag, int'(disp_hi), bcd(m_tot / 6000));
    chk(tag, int'(disp_mid), bcd((m_tot / 100) % 60));
    chk(tag, int'(disp_lo), bcd(m_tot % 100));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int eh, em, es, w, h0, m0, s0, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R6 each view
    chk3("R1 time", 0, 0, 0, 0);
    chk3("R1 date", 1, 0, 1, 1);
    chk3("R1 stopwatch", 2, 0, 0, 0);
    chk3("R6 view3 time", 3, 0, 0, 0);
    chk("R1 weekday", int'(weekday), 6);
    chk("R1 ring", int'(alarm_ring), 0);
    chk("R1 chime", int'(chime), 0);

    // R2/R5: two hours of continuous ticks
    view_sel = 2'd0;
    eh = 0; em = 0; es = 0;
    sec_tick = 1'b1;
    for (int i = 0; i < 7200; i++) begin
      @(negedge clk);
      es++;
      if (es == 60) begin es = 0; em++; end
      if (em == 60) begin em = 0; eh++; end
      #1;
      chk("R2 count", int'({disp_hi, disp_mid, disp_lo}), (bcd(eh) << 16) | (bcd(em) << 8) | bcd(es));
      chk("R5 chime", int'(chime), (em == 0 && es == 0) ? 1 : 0);
    end
    sec_tick = 1'b0;
    @(negedge clk);
    chk("R5 chime drop", int'(chime), 0);

    // R7 field sweeps with wrap
    for (int i = 0; i < 61; i++) begin inc(0); es = (es + 1) % 60; chk3("R7 sec", 0, eh, em, es); end
    for (int i = 0; i < 61; i++) begin inc(1); em = (em + 1) % 60; chk3("R7 min", 0, eh, em, es); end
    for (int i = 0; i < 25; i++) begin inc(2); eh = (eh + 1) % 24; chk3("R7 hour", 0, eh, em, es); end
    w = 6;
    for (int i = 0; i < 8; i++) begin inc(3); w = (w + 1) % 7; chk("R7 wday", int'(weekday), w); end
    d = 1;
    for (int i = 0; i < 32; i++) begin inc(4); d = (d == 31) ? 1 : d + 1; chk3("R7 day", 1, 0, 1, d); end
    for (int i = 0; i < 13; i++) begin inc(5); m0 = (i % 12) + 2; if (m0 == 13) m0 = 1; chk3("R7 month", 1, 0, m0, d); end
    for (int i = 0; i < 101; i++) begin inc(6); chk3("R7 year", 1, (i + 1) % 100, m0, d); end
    // R7: unused field codes and ticks during set mode change nothing
    h0 = int'(u_dummy_read(0)); m0 = int'(u_dummy_read(1)); s0 = int'(u_dummy_read(2));
    inc(9); inc(15);
    chk3("R7 unused field", 0, eh, em, es);
    chk("R7 unused wday", int'(weekday), w);
    sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    chk("R7 tick ignored chime", int'(chime), 0);
    chk3("R7 tick ignored", 0, eh, em, es);

    // R8 clamping
    set_to(6, 1, 0, 1); set_to(5, 1, 1, 1); set_to(4, 1, 2, 31);
    inc(5); chk3("R8 month clamp", 1, 1, 2, 28);
    set_to(6, 1, 0, 0); set_to(5, 1, 1, 1); set_to(4, 1, 2, 31);
    inc(5); chk3("R8 leap clamp", 1, 0, 2, 29);
    inc(6); chk3("R8 year clamp", 1, 1, 2, 28);

    // R2/R3/R4 month-end rollovers
    for (int yi = 0; yi < 5; yi++) begin
      int y;
      y = (yi == 4) ? 99 : yi;
      for (int mo = 1; mo <= 12; mo++) begin
        set_to(6, 1, 0, y); set_to(5, 1, 1, mo); set_to(4, 1, 2, b_dim(mo, y));
        set_to(2, 0, 0, 23); set_to(1, 0, 1, 59); set_to(0, 0, 2, 59);
        w = int'(weekday);
        tick_once();
        chk3("R2 midnight", 0, 0, 0, 0);
        chk3("R4 next day", 1, (mo == 12) ? (y + 1) % 100 : y, (mo == 12) ? 1 : mo + 1, 1);
        chk("R3 weekday", int'(weekday), (w + 1) % 7);
      end
    end

    // R9/R10 alarm at 07:30
    for (int i = 0; i < 30; i++) inc(7);
    for (int i = 0; i < 7; i++) inc(8);
    set_to(2, 0, 0, 7); set_to(1, 0, 1, 29); set_to(0, 0, 2, 58);
    alarm_arm = 1'b1;
    tick_once(); @(negedge clk);
    chk("R9 no early ring", int'(alarm_ring), 0);
    tick_once();
    chk3("R9 alarm time", 0, 7, 30, 0);
    chk("R5 no chime at :30", int'(chime), 0);
    @(negedge clk);
    chk("R9 ring rises", int'(alarm_ring), 1);
    for (int i = 1; i < P_RING; i++) begin
      tick_once(); @(negedge clk);
      chk("R10 still ringing", int'(alarm_ring), 1);
    end
    tick_once(); @(negedge clk);
    chk("R10 timeout", int'(alarm_ring), 0);

    // R10 stop
    set_to(1, 0, 1, 29); set_to(0, 0, 2, 59);
    tick_once(); @(negedge clk);
    chk("R10 ring before stop", int'(alarm_ring), 1);
    alarm_stop = 1'b1; @(negedge clk); alarm_stop = 1'b0;
    chk("R10 stop clears", int'(alarm_ring), 0);
    tick_once(); @(negedge clk);
    chk("R10 stays silent", int'(alarm_ring), 0);

    // R9 disarmed
    alarm_arm = 1'b0;
    set_to(1, 0, 1, 29); set_to(0, 0, 2, 59);
    tick_once(); @(negedge clk);
    chk("R9 disarmed", int'(alarm_ring), 0);

    // R7 alarm field wrap, R9 disarm clears
    for (int i = 0; i < 60; i++) inc(7);
    for (int i = 0; i < 24; i++) inc(8);
    alarm_arm = 1'b1;
    set_to(1, 0, 1, 29); set_to(0, 0, 2, 59);
    tick_once(); @(negedge clk);
    chk("R7 alarm wrap ring", int'(alarm_ring), 1);
    alarm_arm = 1'b0; @(negedge clk);
    chk("R9 disarm clears", int'(alarm_ring), 0);

    // R11/R12 stopwatch
    sw_cyc("R12 clear idle", 0, 0, 1);
    sw_cyc("R11 start", 1, 0, 0);
    for (int i = 0; i < P_WRAP * 6000 * P_CS + 40; i++) sw_cyc("R11 run", 0, 0, 0);
    sw_cyc("R11 stop", 0, 1, 0);
    for (int i = 0; i < 12; i++) sw_cyc("R11 hold", 0, 0, 0);
    sw_cyc("R11 stop wins", 1, 1, 0);
    for (int i = 0; i < 6; i++) sw_cyc("R11 hold2", 0, 0, 0);
    sw_cyc("R11 restart", 1, 0, 0);
    for (int i = 0; i < 50; i++) sw_cyc("R11 run2", 0, 0, 0);
    sw_cyc("R12 clear running", 0, 0, 1);
    for (int i = 0; i < 20; i++) sw_cyc("R12 after clear", 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] u_dummy_read(input int s);
    return 8'(slot(s));
  endfunction

endmodule